// File: doc/BRIEF.md
# Processor Performance Monitoring Counter Unit

This unit keeps three counters that profile a processor core: a cycle counter for total run time and two 32-bit event counters, counter 0 and counter 1. A mode bit chooses the event pair for a run. In instruction translation mode, counter 0 counts executed instructions and counter 1 counts table walks of the instruction translation buffer. In data translation mode, counter 0 counts data cache accesses and counter 1 counts table walks of the data translation buffer. The core drives event strobes every cycle. The data access input carries a count rather than a single bit, because one multi-register load or store adds its register count, and a doubleword load adds two.

Software uses a small register interface. Each counter can be written directly. Software can also set the global enable, the mode, a divide-by-64 prescale for the cycle counter and three interrupt enables, and it can clear each counter with a write-one pulse. A counter that wraps sets a sticky overflow flag, and software clears that flag by writing one to it. The interrupt line is a level that stays high while any overflow flag with its enable set is high, so an overflow of counter 0 can end a sampling window.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all three counters, the control register and the overflow flags are zero, and `irq` is low.
- R2: While the enable bit (control bit 0) is 0, no counter changes except through a software write or clear.
- R3: While enabled with the prescale bit (control bit 2) at 0, the cycle counter adds one per clock.
- R4: A 6-bit prescaler counts enabled clocks from reset. A cycle-counter clear pulse zeroes it. With control bit 2 at 1, the cycle counter adds one only on clocks where the prescaler holds 63.
- R5: With the mode bit (control bit 1) at 0, counter 0 adds `instExec` and counter 1 adds `itlbWalk` each enabled clock.
- R6: With the mode bit at 1, counter 0 adds the value on `dataAccCnt` (0 to 16) and counter 1 adds `dtlbWalk` each enabled clock.
- R7: A walk strobe has no effect on counter 1 while its own buffer's enable input (`itlbOn` or `dtlbOn`) is low.
- R8: An increment that carries out of the top bit sets the counter's overflow flag. The flags read at address 1: bit 0 is the cycle counter, bit 1 is counter 0, bit 2 is counter 1. Writing one to a flag bit clears it. A new overflow in the same clock wins over the clear.
- R9: `irq` is high exactly when some overflow flag is set and its enable is set. The enables are control bits 3, 4 and 5, in the same order as the flags.
- R10: Writing one to control bit 8, 9 or 10 clears the cycle counter, counter 0 or counter 1, in that order, so the counter reads zero in the next clock. These bits read back as zero, and the clear overrides any increment.
- R11: A direct write to a counter takes priority over an increment in the same clock, and that clock sets no overflow flag.
- R12: The register map is: address 0 is control (bits 5:0 readable), 1 is flags, 2 is the cycle counter, 3 is counter 0, 4 is counter 1. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from `regAddr`) |
| instExec | input | 1 | One instruction executed this clock |
| itlbWalk | input | 1 | Instruction translation buffer table walk |
| itlbOn | input | 1 | Instruction translation buffer enabled |
| dataAccCnt | input | 5 | Data cache accesses this clock |
| dtlbWalk | input | 1 | Data translation buffer table walk |
| dtlbOn | input | 1 | Data translation buffer enabled |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong increment, an ungated walk or a missed clear leaves a counter value that is wrong from the next clock on, and because the counters accumulate, the error stays visible at `regRdata`. A wrong prescaler phase shows up only when the cycle counter steps, which can be as late as 64 clocks. A wrong overflow flag shows at address 1 one clock after the wrapping increment. Through the enables, the same fault shows on `irq` in that clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int IDX_CYC = 0;
  localparam int IDX_EV0 = 1;
  localparam int IDX_EV1 = 2;
  localparam int NCNT    = 3;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CYC  = 3'd2;

  // control bit positions
  localparam int B_EN   = 0;
  localparam int B_MODE = 1;
  localparam int B_DIV  = 2;

  typedef struct packed {
    logic                cycStep;
    logic                ev1Step;
    logic [NCNT-1:0]     wr;
    logic [NCNT-1:0]     clr;
  } pmuStrobe_t;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int CW   = 5,
  parameter int DIVW = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWr,
  input  logic [2:0]      regAddr,
  input  logic [8:0]      wdataLo,   // {clear pulses[2:0], control[5:0]}
  input  logic            instExec,
  input  logic            itlbWalk,
  input  logic            itlbOn,
  input  logic [CW-1:0]   dataAccCnt,
  input  logic            dtlbWalk,
  input  logic            dtlbOn,
  input  logic [NCNT-1:0] ovfPulse,
  output pmuStrobe_t      strobe,
  output logic [CW-1:0]   ev0Amt,
  output logic [5:0]      ctrlView,
  output logic [NCNT-1:0] flags,
  output logic            irq
);
  logic [5:0]      ctrlReg;
  logic [DIVW-1:0] pre;
  logic            ctrlWrite;
  logic [NCNT-1:0] statClr;
  logic            en;
  logic            mode;

  assign en        = ctrlReg[B_EN];
  assign mode      = ctrlReg[B_MODE];
  assign ctrlWrite = regWr && (regAddr == ADDR_CTRL);
  assign statClr   = (regWr && regAddr == ADDR_STAT) ? wdataLo[NCNT-1:0] : '0;
  assign ctrlView  = ctrlReg;

  always_comb begin
    strobe = '0;
    for (int k = 0; k < NCNT; k++) begin
      strobe.clr[k] = ctrlWrite && wdataLo[6+k];
      strobe.wr[k]  = regWr && (regAddr == ADDR_CYC + 3'(k));
    end
    strobe.cycStep = en && (!ctrlReg[B_DIV] || (&pre));
    strobe.ev1Step = en && (mode ? (dtlbWalk && dtlbOn) : (itlbWalk && itlbOn));
    ev0Amt = !en ? '0 : (mode ? dataAccCnt : {{(CW-1){1'b0}}, instExec});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      pre     <= '0;
      flags   <= '0;
    end else begin
      if (ctrlWrite) ctrlReg <= wdataLo[5:0];
      if (strobe.clr[IDX_CYC]) pre <= '0;
      else if (en)             pre <= pre + 1'b1;
      flags <= (flags & ~statClr) | ovfPulse;
    end
  end

  assign irq = |(flags & ctrlReg[5:3]);

  for (genvar k = 0; k < NCNT; k++) begin : g_chk
    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[k] |=> flags[k]);
    a_r11_no_flag_on_write: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wr[k] && !flags[k]) |=> !flags[k]);
    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
      (ovfPulse[k] && ctrlReg[3+k] && !ctrlWrite) |=> irq);
  end
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pmuStrobe_t             strobe,
  input  logic [CW-1:0]          ev0Amt,
  input  logic [W-1:0]           wdata,
  output logic [NCNT-1:0][W-1:0] cntAll,
  output logic [NCNT-1:0]        ovfPulse
);
  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic [W-1:0] amt;
    logic [W:0]   sum;
    if (k == IDX_EV0) begin : g_multi
      assign amt = {{(W-CW){1'b0}}, ev0Amt};
    end else if (k == IDX_CYC) begin : g_cyc
      assign amt = {{(W-1){1'b0}}, strobe.cycStep};
    end else begin : g_walk
      assign amt = {{(W-1){1'b0}}, strobe.ev1Step};
    end

    assign sum = {1'b0, cntAll[k]} + {1'b0, amt};
    assign ovfPulse[k] = sum[W] && !strobe.clr[k] && !strobe.wr[k];

    always_ff @(posedge clk) begin
      if (!rstN)              cntAll[k] <= '0;
      else if (strobe.clr[k]) cntAll[k] <= '0;
      else if (strobe.wr[k])  cntAll[k] <= wdata;
      else                    cntAll[k] <= sum[W-1:0];
    end

    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clr[k] |=> (cntAll[k] == '0));
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wr[k] && !strobe.clr[k]) |=> (cntAll[k] == $past(wdata)));
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int W    = 32,
  parameter int CW   = 5,
  parameter int DIVW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic [2:0]    regAddr,
  input  logic [W-1:0]  regWdata,
  output logic [W-1:0]  regRdata,
  input  logic          instExec,
  input  logic          itlbWalk,
  input  logic          itlbOn,
  input  logic [CW-1:0] dataAccCnt,
  input  logic          dtlbWalk,
  input  logic          dtlbOn,
  output logic          irq
);
  pmuStrobe_t             strobe;
  logic [CW-1:0]          ev0Amt;
  logic [5:0]             ctrlView;
  logic [NCNT-1:0]        flags;
  logic [NCNT-1:0]        ovfPulse;
  logic [NCNT-1:0][W-1:0] cntAll;

  pmu_ctrl #(.CW(CW), .DIVW(DIVW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .wdataLo({regWdata[10:8], regWdata[5:0]}),
    .instExec(instExec), .itlbWalk(itlbWalk), .itlbOn(itlbOn),
    .dataAccCnt(dataAccCnt), .dtlbWalk(dtlbWalk), .dtlbOn(dtlbOn),
    .ovfPulse(ovfPulse), .strobe(strobe), .ev0Amt(ev0Amt),
    .ctrlView(ctrlView), .flags(flags), .irq(irq)
  );

  pmu_datapath #(.W(W), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ev0Amt(ev0Amt),
    .wdata(regWdata), .cntAll(cntAll), .ovfPulse(ovfPulse)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      3'd0:    regRdata = {{(W-6){1'b0}}, ctrlView};
      3'd1:    regRdata = {{(W-NCNT){1'b0}}, flags};
      3'd2:    regRdata = cntAll[IDX_CYC];
      3'd3:    regRdata = cntAll[IDX_EV0];
      3'd4:    regRdata = cntAll[IDX_EV1];
      default: regRdata = '0;
    endcase
  end

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlView[B_EN] && !regWr) |=> $stable(cntAll));
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[B_EN] && !ctrlView[B_DIV] &&
     !(regWr && (regAddr == 3'd2 || (regAddr == 3'd0 && regWdata[8]))))
    |=> (cntAll[IDX_CYC] == $past(cntAll[IDX_CYC]) + 1'b1));
  a_r7_itlb_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlView[B_MODE] && !itlbOn &&
     !(regWr && (regAddr == 3'd4 || (regAddr == 3'd0 && regWdata[10]))))
    |=> $stable(cntAll[IDX_EV1]));
  a_r7_dtlb_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[B_MODE] && !dtlbOn &&
     !(regWr && (regAddr == 3'd4 || (regAddr == 3'd0 && regWdata[10]))))
    |=> $stable(cntAll[IDX_EV1]));
endmodule

// File: tb/perf_mon_unit_bench.sv
`timescale 1ns/1ps
module perf_mon_unit_bench;
  localparam int NCYC = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        instExec = 1'b0, itlbWalk = 1'b0, itlbOn = 1'b1;
  logic [4:0]  dataAccCnt = '0;
  logic        dtlbWalk = 1'b0, dtlbOn = 1'b1;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // model state
  logic [5:0]  mCtrl;
  logic [2:0]  mFlags;
  logic [31:0] mCnt [3];
  logic [5:0]  mPre;

  always #2.5 clk = ~clk;

  perf_mon_unit u_perf_mon_unit (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .instExec(instExec),
    .itlbWalk(itlbWalk), .itlbOn(itlbOn), .dataAccCnt(dataAccCnt),
    .dtlbWalk(dtlbWalk), .dtlbOn(dtlbOn), .irq(irq)
  );

  // reference model built from the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mFlags = '0; mPre = '0;
      for (int k = 0; k < 3; k++) mCnt[k] = '0;
    end else begin
      logic        en, mode;
      logic [31:0] amt [3];
      logic [32:0] s;
      logic [2:0]  setF, clrF;
      logic [5:0]  nCtrl;
      en   = mCtrl[0];
      mode = mCtrl[1];
      amt[0] = {31'b0, en && (!mCtrl[2] || mPre == 6'd63)};                    // R3 R4
      amt[1] = !en ? 32'd0 : (mode ? {27'b0, dataAccCnt} : {31'b0, instExec}); // R5 R6
      amt[2] = {31'b0, en && (mode ? (dtlbWalk && dtlbOn) : (itlbWalk && itlbOn))}; // R7
      setF = '0;
      for (int k = 0; k < 3; k++) begin
        if (regWr && regAddr == 3'd0 && regWdata[8+k]) mCnt[k] = '0;         // R10
        else if (regWr && regAddr == 3'(2+k)) mCnt[k] = regWdata;            // R11
        else begin
          s = {1'b0, mCnt[k]} + {1'b0, amt[k]};
          mCnt[k] = s[31:0];
          setF[k] = s[32];                                                   // R8
        end
      end
      clrF = (regWr && regAddr == 3'd1) ? regWdata[2:0] : 3'b0;
      mFlags = (mFlags & ~clrF) | setF;
      if (regWr && regAddr == 3'd0 && regWdata[8]) mPre = '0;
      else if (en) mPre = mPre + 6'd1;
      nCtrl = (regWr && regAddr == 3'd0) ? regWdata[5:0] : mCtrl;
      mCtrl = nCtrl;
    end
  end

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {26'b0, mCtrl};
      3'd1: return {29'b0, mFlags};
      3'd2: return mCnt[0];
      3'd3: return mCnt[1];
      3'd4: return mCnt[2];
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string pre);
    string tags [6];
    tags[0] = "R12 control readback";
    tags[1] = "R8 flags";
    tags[2] = "R2/R3/R4/R10/R11 cycle counter";
    tags[3] = "R2/R5/R6/R10/R11 counter 0";
    tags[4] = "R5/R6/R7/R10/R11 counter 1";
    tags[5] = "R12 unmapped read";
    regWr = 1'b0;
    chk({pre, "R9 irq"}, {31'b0, irq}, {31'b0, |(mFlags & mCtrl[5:3])});
    for (int a = 0; a < 6; a++) begin
      regAddr = 3'(a);
      #0.2;
      chk({pre, tags[a]}, regRdata, expRead(3'(a)));
    end
  endtask

  task automatic randStim();
    instExec   = 1'($urandom);
    itlbWalk   = 1'($urandom);
    dtlbWalk   = 1'($urandom);
    itlbOn     = ($urandom % 4) != 0;
    dtlbOn     = ($urandom % 4) != 0;
    dataAccCnt = 5'($urandom % 17);
    regWr      = ($urandom % 8) == 0;
    regAddr    = 3'($urandom % 6);
    case (regAddr)
      3'd0: regWdata = {21'b0, ($urandom % 4) == 0, ($urandom % 4) == 0,
                        ($urandom % 4) == 0, 2'b0, 3'($urandom),
                        ($urandom % 3) == 0, 1'($urandom), ($urandom % 8) != 0};
      3'd1: regWdata = 32'($urandom % 8);
      default: regWdata = ($urandom % 2) ? (32'hFFFF_FFC0 | 32'($urandom % 64)) : $urandom;
    endcase
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1 reset irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      regAddr = 3'(a); #0.2;
      chk("R1 reset register", regRdata, 32'd0);
    end
    // directed: data mode, counter 0 near wrap with multi-register access
    regWr = 1'b1; regAddr = 3'd3; regWdata = 32'hFFFF_FFFC;
    @(negedge clk); checkAll("directed wr ");
    regWr = 1'b1; regAddr = 3'd0; regWdata = 32'h0000_0013; // en, data mode, irq en ctr0
    @(negedge clk); checkAll("directed ctrl ");
    dataAccCnt = 5'd16; dtlbOn = 1'b0; dtlbWalk = 1'b1;
    @(negedge clk); checkAll("directed wrap ");
    dataAccCnt = 5'd2;
    @(negedge clk); checkAll("directed ldrd ");
    regWr = 1'b1; regAddr = 3'd1; regWdata = 32'h2;
    @(negedge clk); checkAll("directed flagclr ");
    // directed: prescale mode for 130 clocks
    regWr = 1'b1; regAddr = 3'd0; regWdata = 32'h0000_0105;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk); checkAll("directed div64 ");
    end
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      checkAll("");
      randStim();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule